// File: doc/BRIEF.md
# Pseudo-SRAM Power State Sequencer

This block controls the power modes of a one-transistor pseudo-SRAM. It owns the memory's active-high deep-power-down select line and decides when the memory's cycle controller may start accesses. After supply power is good, the line is held high and a stabilisation wait of more than 200 µs must pass before accesses are allowed. A host request then drives the line low, which enters deep power down. The request is taken only while no bus cycle is in flight. A wake request raises the line again and repeats the full stabilisation wait before the memory returns to standby.

Deep power down does not keep the array contents. The sequencer therefore raises a sticky "contents lost" flag on every power-up and on every exit from deep power down, and the host clears the flag with a pulse. Standby and active operation are left to the cycle controller, because neither needs a wait. The wait length is derived from the clock period and the wait time, both given as parameters, so the block can be reused at any clock rate.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, the state output is 0 (power-on wait), the select line is high, access is not allowed and the contents-lost flag is high.
- R2: In the power-on wait, the state moves to 1 (ready) after exactly WAIT_CYC consecutive clock edges with power good high. WAIT_CYC is ceil(WAIT_NS*1000/CLK_PERIOD_PS)+1, which makes the wait strictly longer than WAIT_NS. Access is allowed only in state 1.
- R3: In state 1, a deep-power-down request, whether new or pending, with bus busy low moves the state to 2 on the next edge. The select line drops and access is withdrawn in that same cycle. A request seen while the bus is busy is held until the bus is idle.
- R4: In state 2 the select line stays low and the state is unchanged until a wake request. Deep-power-down requests in state 2 have no effect.
- R5: A wake request in state 2 moves the state to 3 (exit wait) with the select line high. After WAIT_CYC further edges with power good high, the state becomes 1.
- R6: The contents-lost flag is set by reset, by power good being low and by entry to state 3. A lost-clear pulse clears it only when no set condition occurs in the same cycle. Otherwise it holds its value.
- R7: Wake requests in states 0, 1 and 3 have no effect on the state.
- R8: A deep-power-down request made during state 0 or 3 is held. When the wait ends the state goes to 1, and on the next edge with bus busy low it goes to 2.
- R9: Power good low in any state forces state 0 on the next edge. It also restarts the wait count, drops any held request and sets the contents-lost flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply stable indication |
| dpd_req | input | 1 | Request to enter deep power down |
| wake_req | input | 1 | Request to leave deep power down |
| bus_busy | input | 1 | A memory bus cycle is in progress |
| lost_clr | input | 1 | Pulse that clears the contents-lost flag |
| dpd_sel | output | 1 | Level for the memory's deep-power-down select line (low = deep power down) |
| access_ok | output | 1 | Cycle controller may start accesses |
| contents_lost | output | 1 | Sticky flag: memory contents are not valid |
| state_o | output | 2 | 0 power-on wait, 1 ready, 2 deep power down, 3 exit wait |

## Verification
A wrong internal state is visible at once on state_o and, one edge later at most, on dpd_sel and access_ok, because both are decoded from the state register with no pipeline stage. An off-by-one wait counter appears as access_ok rising one cycle early or late against the count derived from the parameters. A lost or stuck pending request shows as a ready period that lasts too long, or as a deep-power-down entry that never happens. A sweep with varied inputs compares every output on every cycle against an arithmetic model, so any wrong transition shows up within one cycle.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int WAIT_NS       = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       dpd_req,
  input  logic       wake_req,
  input  logic       bus_busy,
  input  logic       lost_clr,
  output logic       dpd_sel,
  output logic       access_ok,
  output logic       contents_lost,
  output logic [1:0] state_o
);
  localparam int WAIT_CYC = (WAIT_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS + 1;
  localparam int CNT_W    = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  typedef enum logic [1:0] {
    ST_PON  = 2'd0,
    ST_RDY  = 2'd1,
    ST_DPD  = 2'd2,
    ST_EXIT = 2'd3
  } st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic            pend;
  logic            lost;

  wire waiting  = (st == ST_PON) || (st == ST_EXIT);
  wire wait_end = waiting && (cnt == CNT_LAST);
  wire go_dpd   = (st == ST_RDY) && (dpd_req || pend) && !bus_busy;
  wire go_exit  = (st == ST_DPD) && wake_req;
  wire set_lost = !pwr_good || go_exit;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_good) begin
      st   <= ST_PON;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      case (st)
        ST_PON, ST_EXIT: begin
          if (wait_end) begin
            st  <= ST_RDY;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (dpd_req) pend <= 1'b1;
        end
        ST_RDY: begin
          if (go_dpd) begin
            st   <= ST_DPD;
            pend <= 1'b0;
          end else if (dpd_req) begin
            pend <= 1'b1;
          end
        end
        default: begin
          if (go_exit) begin
            st  <= ST_EXIT;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || set_lost) lost <= 1'b1;
    else if (lost_clr)      lost <= 1'b0;
  end

  assign dpd_sel       = (st != ST_DPD);
  assign access_ok     = (st == ST_RDY);
  assign contents_lost = lost;
  assign state_o       = st;

  // R2
  ready_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDY && $past(st) != ST_RDY) |-> ($past(cnt) == CNT_LAST && $past(pwr_good)));

  // R3
  dpd_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dpd_sel) |-> ($past(!bus_busy) && $past(access_ok)));

  // R4
  dpd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpd_sel && !wake_req && pwr_good) |=> !dpd_sel);

  // R6
  lost_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpd_sel) |-> contents_lost);

  // R6
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (contents_lost && !lost_clr) |=> contents_lost);

  // R7
  pon_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && pwr_good) |=> (state_o == 2'd0 || state_o == 2'd1));

  // R9
  pg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (state_o == 2'd0 && contents_lost && !access_ok));
endmodule

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;
  localparam int CLK_PS = 4000;
  localparam int WNS    = 40;
  localparam int W      = (WNS * 1000 + CLK_PS - 1) / CLK_PS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, dq = 1'b0, wk = 1'b0, bz = 1'b0, clr = 1'b0;
  logic sel, ok, lost;
  logic [1:0] st;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_st, m_cnt;
  bit m_pend, m_lost;

  always #2 clk = ~clk;

  psram_pwr_seq #(.CLK_PERIOD_PS(CLK_PS), .WAIT_NS(WNS)) i_psram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pg), .dpd_req(dq), .wake_req(wk),
    .bus_busy(bz), .lost_clr(clr), .dpd_sel(sel), .access_ok(ok),
    .contents_lost(lost), .state_o(st));

  always @(posedge clk) begin
    bit setl;
    setl = !rst_n || !pg || (m_st == 2 && wk);
    if (setl) m_lost <= 1'b1;
    else if (clr) m_lost <= 1'b0;
    if (!rst_n || !pg) begin
      m_st <= 0; m_cnt <= 0; m_pend <= 1'b0;
    end else begin
      case (m_st)
        0, 3: begin
          if (m_cnt == W - 1) begin m_st <= 1; m_cnt <= 0; end
          else m_cnt <= m_cnt + 1;
          if (dq) m_pend <= 1'b1;
        end
        1: begin
          if ((dq || m_pend) && !bz) begin m_st <= 2; m_pend <= 1'b0; end
          else if (dq) m_pend <= 1'b1;
        end
        default: if (wk) begin m_st <= 3; m_cnt <= 0; end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    chk({tag, " state"}, int'(st), m_st);
    chk({tag, " select"}, int'(sel), int'(m_st != 2));
    chk({tag, " access"}, int'(ok), int'(m_st == 1));
    chk({tag, " lost"}, int'(lost), int'(m_lost));
  endtask

  task automatic cyc(input logic p, input logic d, input logic w, input logic b,
                     input logic c, input string tag);
    pg = p; dq = d; wk = w; bz = b; clr = c;
    @(posedge clk);
    @(negedge clk);
    cmp_model(tag);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    pg = 1'b1;
    @(posedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(st), 0);
    chk("R1 select", int'(sel), 1);
    chk("R1 access", int'(ok), 0);
    chk("R1 lost", int'(lost), 1);
    rst_n = 1'b1;

    // R2 wait length
    for (int i = 0; i < W - 1; i++) cyc(1, 0, 0, 0, 0, "R2 wait");
    chk("R2 still waiting", int'(st), 0);
    cyc(1, 0, 0, 0, 0, "R2 end");
    chk("R2 ready", int'(st), 1);
    chk("R2 access", int'(ok), 1);

    // R7 wake in ready ignored
    cyc(1, 0, 1, 0, 0, "R7 wake ready");
    chk("R7 ready kept", int'(st), 1);

    // R6 clear
    cyc(1, 0, 0, 0, 1, "R6 clear");
    chk("R6 cleared", int'(lost), 0);

    // R3 busy holds request
    cyc(1, 1, 0, 1, 0, "R3 busy");
    chk("R3 busy stays ready", int'(st), 1);
    cyc(1, 0, 0, 1, 0, "R3 busy2");
    chk("R3 still ready", int'(st), 1);
    cyc(1, 0, 0, 0, 0, "R3 idle");
    chk("R3 enter dpd", int'(st), 2);
    chk("R3 select low", int'(sel), 0);
    chk("R3 access off", int'(ok), 0);

    // R4 dpd requests ignored
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, i[0], 0, "R4 hold");
    chk("R4 dpd kept", int'(st), 2);
    chk("R4 lost still clear", int'(lost), 0);

    // R5 wake, R6 lost set, R7 wake in exit ignored, R8 pending
    cyc(1, 0, 1, 0, 0, "R5 wake");
    chk("R5 exit wait", int'(st), 3);
    chk("R5 select high", int'(sel), 1);
    chk("R6 lost on exit", int'(lost), 1);
    cyc(1, 1, 1, 0, 0, "R8 req in exit");
    for (int i = 0; i < W - 2; i++) cyc(1, 0, 1, 0, 0, "R7 wake exit");
    chk("R7 exit kept", int'(st), 3);
    cyc(1, 0, 0, 0, 0, "R5 end");
    chk("R5 ready", int'(st), 1);
    cyc(1, 0, 0, 0, 0, "R8 act");
    chk("R8 pending dpd", int'(st), 2);

    // R9 power drop in exit wait, R6 set beats clear
    cyc(1, 0, 1, 0, 0, "R9 wake");
    cyc(1, 1, 0, 0, 1, "R9 clr");
    cyc(0, 0, 0, 0, 1, "R9 drop");
    chk("R9 pon", int'(st), 0);
    chk("R6 set beats clear", int'(lost), 1);
    for (int i = 0; i < W - 1; i++) cyc(1, 0, 0, 0, 0, "R9 restart");
    chk("R9 counter restarted", int'(st), 0);
    cyc(1, 0, 0, 0, 0, "R9 ready");
    chk("R9 ready again", int'(st), 1);

    // sweep against model (R2 R3 R4 R5 R6 R7 R8 R9)
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[15:11] != 5'd0, lfsr[0] & lfsr[3], lfsr[1] & lfsr[4],
          lfsr[2], lfsr[5] & lfsr[6] & lfsr[7], "R8 sweep");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule